// File: doc/BRIEF.md
# Pseudo-Cause Interrupt Aggregator

This block folds three group interrupt requests (receive, transmit and miscellaneous) into a single summary word and one host interrupt line. Each group owns one bit of the summary word. That bit is sticky: it is set whenever the group's request input is high, and it stays set until the host reads the summary word. A read both returns the word and clears it, so the host needs no separate acknowledge step.

A software mask word decides which summary bits may drive the host interrupt line. After reset every bit is masked. The host unmasks by writing a word that has zeros at the three group positions and ones in every other bit. Because only three bits of the summary word can ever be set, its low byte can never read back as all ones. The host relies on that value to spot a dead or absent device.

Access is through a small 32-bit register port with a word address, a read strobe and a write strobe. Read data comes back registered, one cycle after the strobe, together with a valid flag.

Top module: `pseudo_cause_agg`

## Requirements
- R1: After reset the summary word is 0, the mask word is 0xFFFFFFFF, host_irq_o is 0 and rd_valid_o is 0.
- R2: A high group input sets its summary bit at the next clock edge, at bit 0 for receive, bit 1 for transmit and bit 2 for miscellaneous. The bit stays set after the input drops.
- R3: A read strobe at address 0 returns the summary word on rd_data_o, with rd_valid_o high, in the cycle after the strobe. Bits 31..3 of that word are zero.
- R4: A read of address 0 clears every summary bit whose group input is low in the read cycle. A bit whose group input is high in that cycle reads 1 again afterwards.
- R5: A write strobe at address 1 stores the full 32-bit mask word. A read of address 1 returns the stored value.
- R6: host_irq_o is high exactly when some summary bit is 1 and the mask bit at the same position is 0. With the mask word all ones, host_irq_o stays low.
- R7: A summary readout never has its low byte equal to 0xFF.
- R8: Reading or writing the mask word does not change the summary word. A write to address 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| grp_irq_i | input | 3 | Group requests: [0] receive, [1] transmit, [2] miscellaneous |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 2 | Word address: 0 summary, 1 mask, others read as zero |
| bus_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | High in the cycle after a read strobe |
| host_irq_o | output | 1 | Host interrupt line |

## Verification
The assertions assume that read and write strobes never arrive in the same cycle. They also assume that group inputs and strobes change only between clock edges and hold steady across each edge. The stimulus meets both conditions by issuing one bus operation per cycle, with every input driven on the falling edge. The clear checks rely on the group inputs being sampled in the same cycle as the read. The bench therefore covers both cases: a group input held high through a read, and a group input low during a read.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int unsigned PCA_NGRP   = 3;
  localparam int unsigned PCA_DATA_W = 32;
  localparam int unsigned PCA_ADDR_W = 2;
  localparam logic [PCA_ADDR_W-1:0] PCA_ADDR_SUM  = 2'd0;
  localparam logic [PCA_ADDR_W-1:0] PCA_ADDR_MASK = 2'd1;
  localparam logic [PCA_DATA_W-1:0] PCA_MASK_RST  = '1;
endpackage

// File: rtl/pca_rst_sync.sv
module pca_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pca_summary.sv
module pca_summary #(
  parameter int unsigned NGRP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] ev_i,
  input  logic            clr_i,
  output logic [NGRP-1:0] sum_o
);
  logic [NGRP-1:0] sum_q;
  logic [NGRP-1:0] sum_d;

  // A clearing read keeps only events present in the same cycle.
  always_comb begin
    if (clr_i) sum_d = ev_i;
    else       sum_d = sum_q | ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[g] |=> sum_q[g]);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_q[g] && !clr_i) |=> sum_q[g]);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !ev_i[g]) |=> !sum_q[g]);
  end
endmodule

// File: rtl/pca_mask.sv
module pca_mask #(
  parameter int unsigned         DATA_W  = 32,
  parameter logic [DATA_W-1:0]   RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= RST_VAL;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mask_q));
  assert_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/pseudo_cause_agg.sv
module pseudo_cause_agg #(
  parameter int unsigned RX_POS   = 0,
  parameter int unsigned TX_POS   = 1,
  parameter int unsigned MISC_POS = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [pca_pkg::PCA_NGRP-1:0]        grp_irq_i,
  input  logic                                bus_rd_i,
  input  logic                                bus_wr_i,
  input  logic [pca_pkg::PCA_ADDR_W-1:0]      bus_addr_i,
  input  logic [pca_pkg::PCA_DATA_W-1:0]      bus_wdata_i,
  output logic [pca_pkg::PCA_DATA_W-1:0]      rd_data_o,
  output logic                                rd_valid_o,
  output logic                                host_irq_o
);
  import pca_pkg::*;

  localparam int unsigned NGRP   = PCA_NGRP;
  localparam int unsigned DATA_W = PCA_DATA_W;
  localparam int unsigned POS [NGRP] = '{RX_POS, TX_POS, MISC_POS};

  logic              rst_sync_n;
  logic              rd_sum, rd_mask, wr_mask;
  logic [NGRP-1:0]   sum_bits;
  logic [NGRP-1:0]   grp_mask;
  logic [DATA_W-1:0] sum_word;
  logic [DATA_W-1:0] mask_word;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_d, rvalid_q;
  logic              rsum_d, rsum_q;

  pca_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign rd_sum  = bus_rd_i && (bus_addr_i == PCA_ADDR_SUM);
  assign rd_mask = bus_rd_i && (bus_addr_i == PCA_ADDR_MASK);
  assign wr_mask = bus_wr_i && (bus_addr_i == PCA_ADDR_MASK);

  pca_summary #(.NGRP(NGRP)) u_sum (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ev_i  (grp_irq_i),
    .clr_i (rd_sum),
    .sum_o (sum_bits)
  );

  pca_mask #(.DATA_W(DATA_W), .RST_VAL(PCA_MASK_RST)) u_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en_i (wr_mask),
    .wdata_i (bus_wdata_i),
    .mask_o  (mask_word)
  );

  // Place each group bit at its configured position in the summary word.
  for (genvar g = 0; g < NGRP; g++) begin : g_map
    assign grp_mask[g] = mask_word[POS[g]];
  end

  always_comb begin
    sum_word = '0;
    for (int g = 0; g < NGRP; g++) sum_word[POS[g]] = sum_bits[g];
  end

  assign host_irq_o = |(sum_bits & ~grp_mask);

  // Registered read port with a clock enable on the data register.
  always_comb begin
    rvalid_d = bus_rd_i;
    rsum_d   = rd_sum;
    rdata_d  = rdata_q;
    if (bus_rd_i) begin
      if (rd_sum)       rdata_d = sum_word;
      else if (rd_mask) rdata_d = mask_word;
      else              rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      rsum_q   <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
      rsum_q   <= rsum_d;
    end
  end

  assign rd_data_o  = rdata_q;
  assign rd_valid_o = rvalid_q;

  assert_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rd_i |=> rd_valid_o);
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid_o && rsum_q && NGRP <= 3 && RX_POS < 3 && TX_POS < 3 && MISC_POS < 3)
      |-> (rd_data_o[DATA_W-1:3] == '0));
  assert_lowbyte_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid_o && rsum_q) |-> (rd_data_o[7:0] != 8'hFF));
  assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&grp_mask) |-> !host_irq_o);
  assert_cause_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_irq_o |-> (sum_word != '0));
endmodule

// File: tb/tb_pseudo_cause_agg.sv
module tb_pseudo_cause_agg;
  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  grp_irq_i = '0;
  logic        bus_rd_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;
  logic        host_irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  exp_t        sb_q[$];
  logic [2:0]  sum_m  = '0;
  logic [31:0] mask_m = 32'hFFFF_FFFF;

  always #2 clk = ~clk;

  pseudo_cause_agg dut (
    .clk(clk), .rst_n(rst_n), .grp_irq_i(grp_irq_i),
    .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .host_irq_o(host_irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver: one bus operation per cycle, model updated right after the edge.
  task automatic op(input logic [2:0] g, input bit rd, input bit wr,
                    input logic [1:0] a, input logic [31:0] wd, input string tag);
    exp_t e;
    grp_irq_i = g; bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = wd;
    @(posedge clk);
    #1;
    if (rd) begin
      e.tag = tag;
      if (a == 2'd0)      e.val = {29'd0, sum_m};
      else if (a == 2'd1) e.val = mask_m;
      else                e.val = '0;
      sb_q.push_back(e);
    end
    if (rd && a == 2'd0) sum_m = g;
    else                 sum_m = sum_m | g;
    if (wr && a == 2'd1) mask_m = wd;
    @(negedge clk);
  endtask

  // Monitor: compares read results and the interrupt line at each falling edge.
  always @(negedge clk) begin
    if (running) begin
      if (rd_valid_o) begin
        if (sb_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3: actual unexpected read 0x%08h expected none", rd_data_o);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(e.tag, rd_data_o, e.val);
          if (e.tag == "R7") chk("R7", {31'd0, rd_data_o[7:0] == 8'hFF}, 32'd0);
        end
      end
      chk("R6", {31'd0, host_irq_o}, {31'd0, |(sum_m & ~mask_m[2:0])});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    chk("R1", {31'd0, host_irq_o}, 32'd0);
    chk("R1", {31'd0, rd_valid_o}, 32'd0);
    chk("R1", rd_data_o, 32'd0);
    running = 1'b1;
    op(3'b000, 1, 0, 2'd1, 0, "R1");
    op(3'b000, 1, 0, 2'd0, 0, "R1");
    // R2 single receive pulse, sticky, R3 readback
    op(3'b001, 0, 0, 2'd0, 0, "R2");
    op(3'b000, 0, 0, 2'd0, 0, "R2");
    op(3'b000, 1, 0, 2'd0, 0, "R3");
    op(3'b000, 1, 0, 2'd0, 0, "R4");
    // R6 masked then unmasked, R5 mask readback
    op(3'b010, 0, 0, 2'd0, 0, "R6");
    op(3'b000, 0, 1, 2'd1, 32'hFFFF_FFF8, "R5");
    op(3'b000, 1, 0, 2'd1, 0, "R5");
    op(3'b000, 1, 0, 2'd0, 0, "R2");
    op(3'b000, 0, 0, 2'd0, 0, "R6");
    // R4 miscellaneous held through a clearing read
    op(3'b100, 0, 0, 2'd0, 0, "R4");
    op(3'b100, 1, 0, 2'd0, 0, "R4");
    op(3'b000, 1, 0, 2'd0, 0, "R4");
    op(3'b000, 1, 0, 2'd0, 0, "R4");
    // R7 all groups at once
    op(3'b111, 0, 0, 2'd0, 0, "R7");
    op(3'b000, 1, 0, 2'd0, 0, "R7");
    // R8 summary write ignored, mask access leaves summary intact
    op(3'b011, 0, 0, 2'd0, 0, "R8");
    op(3'b000, 0, 1, 2'd0, 32'h0, "R8");
    op(3'b000, 1, 0, 2'd1, 0, "R8");
    op(3'b000, 0, 1, 2'd1, 32'hFFFF_FFF8, "R8");
    op(3'b000, 1, 0, 2'd0, 0, "R8");
    // R6 only transmit unmasked
    op(3'b000, 0, 1, 2'd1, 32'hFFFF_FFFD, "R6");
    op(3'b001, 0, 0, 2'd0, 0, "R6");
    op(3'b000, 0, 0, 2'd0, 0, "R6");
    op(3'b010, 0, 0, 2'd0, 0, "R6");
    op(3'b000, 1, 0, 2'd0, 0, "R4");
    op(3'b000, 0, 1, 2'd1, 32'hFFFF_FFFF, "R6");
    op(3'b111, 0, 0, 2'd0, 0, "R6");
    op(3'b000, 1, 0, 2'd3, 0, "R3");
    op(3'b000, 0, 0, 2'd0, 0, "R3");
    running = 1'b0;
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R3: actual %0d pending reads expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule